// File: doc/BRIEF.md
# Wrapping Prefetch Request Line Generator

This block produces the sequence of line-wide address requests that a double-buffered operand memory sends to backing memory. The operand address stream sits in a preloaded line store, packed row-major with `BW` addresses per line. Unused slots hold the all-ones invalid address. When a burst is started, the generator picks a first line and a line count. It reads each line from the store through a combinational index/data pair. It blanks the slots that must not be fetched and presents one line per cycle on a valid/ready request port. Each line carries a timestamp of when it would be issued.

There are two burst kinds. An initial fill always begins at line 0 and covers the active region. A refill begins at the saved next-line pointer, covers the prefetch region, and wraps past the last line back to line 0. The generator keeps a next-line pointer and a next-column pointer across bursts. It updates both when a burst ends, so the next refill neither re-fetches slots already fetched nor fetches beyond buffer capacity.

Back-pressure rules: `req_valid` is high for the whole burst. A line counts as transferred only on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the address, mask and timestamp of the presented line stay unchanged. The next line appears in the cycle after a transfer.

Top module: `prefetch_line_gen`

## Requirements
- R1: After reset, `req_valid` and `done` are 0 and both `ptr_line` and `ptr_col` are 0.
- R2: An initial fill (`start` with `start_init`=1) issues lines 0, 1, ... in order. The line count is the smaller of ceil(`cfg_active_words`/BW) and `cfg_total_lines`.
- R3: A refill (`start` with `start_init`=0) begins at `ptr_line` and requests ceil(`cfg_prefetch_words`/BW) lines, with indices going past the last line wrapping to 0. The wrapped part is cut at `ptr_line` lines, so at most `cfg_total_lines` lines are issued. `store_idx` shows the line index being issued.
- R4: In the first line of a refill, slots with index below `ptr_col` are invalid. An initial fill masks no leading slots.
- R5: When requested lines × BW exceeds `cfg_active_words`, the slots of the last issued line with index ≥ (`cfg_active_words` mod BW) are invalid. The next-column pointer becomes that value; otherwise it becomes 0.
- R6: Slot j occupies `req_addr[j*ADDR_W +: ADDR_W]` and `req_mask[j]`. A slot whose store word is all ones is invalid, and every invalid slot carries the all-ones address with mask bit 0.
- R7: Line k (k = 0 for the first) of a burst carries `req_cycle` = `last_done_cycle` (sampled at start) + k + 1.
- R8: At the end of a burst, `ptr_line` becomes (requested lines) mod `cfg_total_lines` if the last line was cut by R5, and (requested lines + 1) mod `cfg_total_lines` otherwise.
- R9: While `req_valid` is high and `req_ready` is low, `store_idx`, `req_addr`, `req_mask` and `req_cycle` hold. Exactly one line advances per transfer.
- R10: `done` is a one-cycle pulse in the cycle after the last line is transferred. `req_valid` is low in that cycle, and the updated pointers show in that same cycle.
- R11: `start` and the configuration inputs are ignored while a burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst when idle |
| start_init | input | 1 | 1: initial fill, 0: refill |
| cfg_total_lines | input | SIZE_W | Number of lines in the operand stream |
| cfg_active_words | input | SIZE_W | Active region size in words |
| cfg_prefetch_words | input | SIZE_W | Prefetch region size in words |
| last_done_cycle | input | CYC_W | Completion cycle of the previous prefetch |
| store_idx | output | SIZE_W | Line index read from the operand line store |
| store_line | input | BW*ADDR_W | Addresses of the indexed line (combinational) |
| req_valid | output | 1 | Request line present |
| req_ready | input | 1 | Backing side accepts the line |
| req_addr | output | BW*ADDR_W | Line of addresses, invalid slots all ones |
| req_mask | output | BW | Per-slot valid bits |
| req_cycle | output | CYC_W | Issue timestamp of the line |
| done | output | 1 | Burst finished pulse |
| ptr_line | output | SIZE_W | Next-line pointer |
| ptr_col | output | COL_W | Next-column pointer |

## Verification
A `start` sampled at a rising edge makes line 0 visible one cycle later. Each transferred line is replaced in the cycle after its transfer edge. `done` and the updated pointers appear in the cycle after the last transfer, and `done` drops again one cycle after that. The bench drives every input and samples every output at the falling edge. It walks a burst one falling edge at a time: it compares the presented line when `req_valid` is high, and it moves to the next expected line only if it had driven `req_ready` high for the edge in between. Under stalls, the same expected line is therefore compared again. `done` and the pointers are checked on the falling edge after the last transfer, and the pulse is checked to have dropped on the falling edge after that.

// File: rtl/pfgen_pkg.sv
package pfgen_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_ISSUE = 1'b1} gen_state_e;
endpackage

// File: rtl/pfgen_plan.sv
module pfgen_plan #(
  parameter int BW     = 4,
  parameter int SIZE_W = 16,
  parameter int COL_W  = 2
) (
  input  logic              init_mode,
  input  logic [SIZE_W-1:0] ptr_line,
  input  logic [COL_W-1:0]  ptr_col,
  input  logic [SIZE_W-1:0] total,
  input  logic [SIZE_W-1:0] active,
  input  logic [SIZE_W-1:0] prefetch,
  output logic [SIZE_W-1:0] first_idx,
  output logic [SIZE_W-1:0] n_lines,
  output logic [COL_W-1:0]  skip_cols,
  output logic [COL_W-1:0]  keep_cols,
  output logic              part_last,
  output logic [SIZE_W-1:0] nxt_line,
  output logic [COL_W-1:0]  nxt_col
);
  localparam int WW = SIZE_W + COL_W + 2;

  logic [WW-1:0] act_w, tot_w, ceil_act, ceil_pf, n_req, prod;
  logic [WW-1:0] st_w, end_w, over, wrap_n, issue_w, nxt_w;

  always_comb begin
    act_w    = WW'(active);
    tot_w    = WW'(total);
    ceil_act = (act_w + WW'(BW - 1)) / WW'(BW);
    ceil_pf  = (WW'(prefetch) + WW'(BW - 1)) / WW'(BW);
    if (init_mode) n_req = (ceil_act > tot_w) ? tot_w : ceil_act;
    else           n_req = ceil_pf;
    st_w    = init_mode ? '0 : WW'(ptr_line);
    prod    = n_req * WW'(BW);
    end_w   = st_w + n_req;
    over    = '0;
    wrap_n  = '0;
    issue_w = n_req;
    if (end_w > tot_w) begin
      over    = end_w - tot_w;
      wrap_n  = (over > st_w) ? st_w : over;
      issue_w = (tot_w - st_w) + wrap_n;
    end
    if (tot_w == '0)   nxt_w = '0;
    else if (prod > act_w) nxt_w = n_req % tot_w;
    else               nxt_w = (n_req + WW'(1)) % tot_w;
  end

  assign part_last = prod > act_w;
  assign keep_cols = COL_W'(act_w % WW'(BW));
  assign skip_cols = init_mode ? '0 : ptr_col;
  assign first_idx = SIZE_W'(st_w);
  assign n_lines   = SIZE_W'(issue_w);
  assign nxt_line  = SIZE_W'(nxt_w);
  assign nxt_col   = part_last ? keep_cols : '0;
endmodule

// File: rtl/pfgen_mask.sv
module pfgen_mask #(
  parameter int BW     = 4,
  parameter int ADDR_W = 16,
  parameter int COL_W  = 2
) (
  input  logic [BW*ADDR_W-1:0] line_in,
  input  logic                 is_first,
  input  logic                 is_last,
  input  logic                 part_last,
  input  logic [COL_W-1:0]     skip_cols,
  input  logic [COL_W-1:0]     keep_cols,
  output logic [BW*ADDR_W-1:0] line_out,
  output logic [BW-1:0]        slot_vld
);
  for (genvar j = 0; j < BW; j++) begin : g_slot
    localparam logic [COL_W-1:0] JC = COL_W'(j);
    logic [ADDR_W-1:0] word;
    logic              early, late, sent;
    assign word  = line_in[j*ADDR_W +: ADDR_W];
    assign early = is_first && (JC < skip_cols);
    assign late  = is_last && part_last && (JC >= keep_cols);
    assign sent  = (word == '1);
    assign slot_vld[j] = !(early || late || sent);
    assign line_out[j*ADDR_W +: ADDR_W] = slot_vld[j] ? word : '1;
  end
endmodule

// File: rtl/prefetch_line_gen.sv
module prefetch_line_gen
  import pfgen_pkg::*;
#(
  parameter int BW     = 4,
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 16,
  parameter int CYC_W  = 32,
  localparam int COL_W = (BW > 1) ? $clog2(BW) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_init,
  input  logic [SIZE_W-1:0]    cfg_total_lines,
  input  logic [SIZE_W-1:0]    cfg_active_words,
  input  logic [SIZE_W-1:0]    cfg_prefetch_words,
  input  logic [CYC_W-1:0]     last_done_cycle,
  output logic [SIZE_W-1:0]    store_idx,
  input  logic [BW*ADDR_W-1:0] store_line,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [BW*ADDR_W-1:0] req_addr,
  output logic [BW-1:0]        req_mask,
  output logic [CYC_W-1:0]     req_cycle,
  output logic                 done,
  output logic [SIZE_W-1:0]    ptr_line,
  output logic [COL_W-1:0]     ptr_col
);
  gen_state_e        state_q;
  logic [SIZE_W-1:0] k_q, nl_q, st_q, total_q, nxl_q;
  logic [COL_W-1:0]  sk_q, kp_q, nxc_q;
  logic              part_q, done_q;
  logic [CYC_W-1:0]  base_q;
  logic [SIZE_W-1:0] ptr_line_q;
  logic [COL_W-1:0]  ptr_col_q;

  logic [SIZE_W-1:0] p_first, p_lines, p_nxl;
  logic [COL_W-1:0]  p_skip, p_keep, p_nxc;
  logic              p_part;

  pfgen_plan #(.BW(BW), .SIZE_W(SIZE_W), .COL_W(COL_W)) u_plan (
    .init_mode (start_init),
    .ptr_line  (ptr_line_q),
    .ptr_col   (ptr_col_q),
    .total     (cfg_total_lines),
    .active    (cfg_active_words),
    .prefetch  (cfg_prefetch_words),
    .first_idx (p_first),
    .n_lines   (p_lines),
    .skip_cols (p_skip),
    .keep_cols (p_keep),
    .part_last (p_part),
    .nxt_line  (p_nxl),
    .nxt_col   (p_nxc)
  );

  logic [SIZE_W:0] idx_sum;
  logic            is_first, is_last;

  assign idx_sum   = {1'b0, st_q} + {1'b0, k_q};
  assign store_idx = (idx_sum >= {1'b0, total_q}) ? SIZE_W'(idx_sum - {1'b0, total_q})
                                                  : SIZE_W'(idx_sum);
  assign is_first  = (k_q == '0);
  assign is_last   = (k_q == nl_q - SIZE_W'(1));
  assign req_valid = (state_q == ST_ISSUE);
  assign req_cycle = base_q + CYC_W'(k_q) + CYC_W'(1);
  assign done      = done_q;
  assign ptr_line  = ptr_line_q;
  assign ptr_col   = ptr_col_q;

  pfgen_mask #(.BW(BW), .ADDR_W(ADDR_W), .COL_W(COL_W)) u_mask (
    .line_in   (store_line),
    .is_first  (is_first),
    .is_last   (is_last),
    .part_last (part_q),
    .skip_cols (sk_q),
    .keep_cols (kp_q),
    .line_out  (req_addr),
    .slot_vld  (req_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      k_q        <= '0;
      nl_q       <= '0;
      st_q       <= '0;
      total_q    <= '0;
      nxl_q      <= '0;
      sk_q       <= '0;
      kp_q       <= '0;
      nxc_q      <= '0;
      part_q     <= 1'b0;
      base_q     <= '0;
      done_q     <= 1'b0;
      ptr_line_q <= '0;
      ptr_col_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            k_q     <= '0;
            nl_q    <= p_lines;
            st_q    <= p_first;
            total_q <= cfg_total_lines;
            sk_q    <= p_skip;
            kp_q    <= p_keep;
            part_q  <= p_part;
            nxl_q   <= p_nxl;
            nxc_q   <= p_nxc;
            base_q  <= last_done_cycle;
            if (p_lines == '0) done_q  <= 1'b1;
            else               state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (req_ready) begin
            if (is_last) begin
              state_q    <= ST_IDLE;
              ptr_line_q <= nxl_q;
              ptr_col_q  <= nxc_q;
              done_q     <= 1'b1;
            end else begin
              k_q <= k_q + SIZE_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(store_idx) && $stable(req_cycle)
                                   && $stable(req_mask) && $stable(req_addr)));

  p_cycle_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !is_last) |=> (req_cycle == $past(req_cycle) + CYC_W'(1)));

  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (store_idx < total_q));

  p_first_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_first && (sk_q != '0)) |-> !req_mask[0]);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  p_ptr_only_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || ($stable(ptr_line) && $stable(ptr_col))));
endmodule

// File: tb/prefetch_line_gen_tb.sv
module prefetch_line_gen_tb;
  localparam int BW = 4, AW = 16, SW = 16, CW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, start_init = 1'b0, req_ready = 1'b0;
  logic [SW-1:0] cfg_total_lines = '0, cfg_active_words = '0, cfg_prefetch_words = '0;
  logic [CW-1:0] last_done_cycle = '0;
  logic [SW-1:0] store_idx, ptr_line;
  logic [BW*AW-1:0] store_line, req_addr;
  logic req_valid, done;
  logic [BW-1:0] req_mask;
  logic [CW-1:0] req_cycle;
  logic [1:0] ptr_col;

  int checks = 0, failures = 0, slen = 40;
  int m_line = 0, m_col = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  prefetch_line_gen #(.BW(BW), .ADDR_W(AW), .SIZE_W(SW), .CYC_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_init(start_init),
    .cfg_total_lines(cfg_total_lines), .cfg_active_words(cfg_active_words),
    .cfg_prefetch_words(cfg_prefetch_words), .last_done_cycle(last_done_cycle),
    .store_idx(store_idx), .store_line(store_line), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_mask(req_mask),
    .req_cycle(req_cycle), .done(done), .ptr_line(ptr_line), .ptr_col(ptr_col));

  always_comb begin
    for (int j = 0; j < BW; j++) begin
      int w;
      w = int'(store_idx) * BW + j;
      store_line[j*AW +: AW] = (w < slen) ? AW'(w) : {AW{1'b1}};
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic run_burst(input bit init, input int pf, input int act, input int tot,
                           input int base, input bit stall, input bit poke);
    int nreq, st, sk, keep, nl, k, cyc;
    bit part;
    nreq = init ? (((act + BW - 1) / BW < tot) ? (act + BW - 1) / BW : tot) : (pf + BW - 1) / BW;
    st   = init ? 0 : m_line;
    sk   = init ? 0 : m_col;
    part = (nreq * BW) > act;
    keep = act % BW;
    if (st + nreq > tot) nl = (tot - st) + ((st + nreq - tot < st) ? st + nreq - tot : st);
    else nl = nreq;
    @(negedge clk);
    cfg_total_lines = SW'(tot); cfg_active_words = SW'(act); cfg_prefetch_words = SW'(pf);
    last_done_cycle = CW'(base); start_init = init; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; cyc = 0;
    while (k < nl && cyc < 4000) begin
      int idx;
      logic [BW-1:0] em;
      logic [BW*AW-1:0] ea;
      idx = (st + k) % tot;
      for (int j = 0; j < BW; j++) begin
        bit v;
        v = !(k == 0 && j < sk) && !(k == nl - 1 && part && j >= keep) && (idx * BW + j < slen);
        em[j] = v;
        ea[j*AW +: AW] = v ? AW'(idx * BW + j) : {AW{1'b1}};
      end
      chk(req_valid == 1'b1, "R9", "req_valid during burst", req_valid, 1);
      chk(store_idx == SW'(idx), init ? "R2" : "R3", "line index", store_idx, idx);
      chk(req_mask == em, (k == 0) ? "R4" : "R5", "slot mask", req_mask, em);
      chk(req_addr == ea, "R6", "line addresses", req_addr, ea);
      chk(req_cycle == CW'(base + k + 1), "R7", "issue cycle", req_cycle, base + k + 1);
      req_ready = stall ? cyc[0] : 1'b1;
      if (poke && k == 1) begin
        start = 1'b1; start_init = 1'b1; cfg_total_lines = 3; cfg_prefetch_words = 4;
      end else start = 1'b0;
      @(negedge clk);
      if (req_ready) k++;
      cyc++;
    end
    start = 1'b0; req_ready = 1'b0;
    m_line = (part ? nreq : nreq + 1) % tot;
    m_col  = part ? keep : 0;
    chk(done == 1'b1, "R10", "done after last line", done, 1);
    chk(req_valid == 1'b0, "R10", "valid low at done", req_valid, 0);
    chk(ptr_line == SW'(m_line), "R8", "next-line pointer", ptr_line, m_line);
    chk(ptr_col == 2'(m_col), "R5", "next-column pointer", ptr_col, m_col);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done is one pulse", done, 0);
  endtask

  task automatic t_reset_r1();
    chk(req_valid == 1'b0, "R1", "valid after reset", req_valid, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(ptr_line == '0, "R1", "ptr_line after reset", ptr_line, 0);
    chk(ptr_col == '0, "R1", "ptr_col after reset", ptr_col, 0);
  endtask

  task automatic t_init_fill_r2();
    slen = 40;
    run_burst(1, 0, 18, 10, 100, 0, 0);
    chk(ptr_line == 5, "R8", "init fill line pointer", ptr_line, 5);
    chk(ptr_col == 2, "R5", "init fill column pointer", ptr_col, 2);
  endtask

  task automatic t_refill_r4();
    run_burst(0, 8, 18, 10, 200, 0, 0);
    chk(ptr_line == 3, "R8", "refill line pointer", ptr_line, 3);
    chk(ptr_col == 0, "R5", "refill column pointer", ptr_col, 0);
  endtask

  task automatic t_wrap_stall_r3();
    run_burst(0, 32, 18, 10, 300, 1, 0);
    chk(ptr_line == 8, "R3", "wrap line pointer", ptr_line, 8);
  endtask

  task automatic t_wrap_limit_r3();
    run_burst(0, 48, 18, 10, 400, 0, 0);
    chk(ptr_line == 2, "R3", "wrap limit line pointer", ptr_line, 2);
  endtask

  task automatic t_sentinel_cap_r6();
    slen = 38;
    run_burst(1, 0, 100, 10, 500, 0, 0);
    chk(ptr_line == 1, "R2", "capped fill line pointer", ptr_line, 1);
  endtask

  task automatic t_start_ignored_r11();
    run_burst(0, 12, 100, 10, 600, 0, 1);
    chk(ptr_line == 4, "R11", "poke did not alter pointer", ptr_line, 4);
    repeat (3) begin
      @(negedge clk);
      chk(req_valid == 1'b0, "R11", "no burst from ignored start", req_valid, 0);
    end
  endtask

  task automatic t_reset_clears_r1();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_init_fill_r2();
    t_refill_r4();
    t_wrap_stall_r3();
    t_wrap_limit_r3();
    t_sentinel_cap_r6();
    t_start_ignored_r11();
    t_reset_clears_r1();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule